// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block divides the core clock down to the serial clock of an SPI master. It reads an 8-bit prescale field and turns it into a total divide ratio. It then produces a registered serial clock level, a one-cycle strobe on every half-period toggle, and a flag that tells the shift engine whether that toggle is a rising or a falling edge. Two encodings of the field exist, and a build-time parameter picks one of them.

In the legacy encoding the low nibble N gives a ratio of 2N, clamped to a floor of 4. In the extended encoding, a 4-bit mantissa is shifted left by a 3-bit exponent. The exponent is spread over bit 4 and bits [7:6]. A new ratio is taken only at the end of a full serial clock period (the rising toggle). It is not taken while the shift engine reports a word in progress, so a word is never clocked with mixed periods.

Top module: `spi_clk_presc`

## Requirements
- R1: Legacy format: the ratio is 2N, where N = field[3:0], for N from 2 to 15. Field bits [7:4] have no effect.
- R2: Legacy format: for N of 0 or 1 the ratio is clamped to 4. No half-period is ever shorter than 2 core cycles.
- R3: Extended format: mantissa M = field[3:0], exponent E = {field[7:6], field[4]}, and the ratio is M × 2^E. Field bit 5 has no effect.
- R4: Extended format: a mantissa of 0 or 1 is used as 2, giving a ratio of 2 × 2^E.
- R5: Extended format: the largest ratio is 1920 (M = 15, E = 7), so no half-period exceeds 960 core cycles.
- R6: The high phase lasts ceil(ratio/2) core cycles and the low phase lasts floor(ratio/2). An odd ratio therefore gives the extra cycle to the high phase.
- R7: A change of the field during a period leaves that period unchanged. The new ratio applies from the next rising toggle.
- R8: While word_busy_i is high at a rising toggle, the old ratio is kept for the next period.
- R9: During reset the level is low and no strobe is given. The first rising strobe comes in the first cycle after reset is released.
- R10: half_tick_o is high exactly in the cycles where sck_lvl_o has just changed. edge_rise_o is high only with half_tick_o, and only when the new level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_field_i | input | 8 | Prescale field in the selected encoding |
| word_busy_i | input | 1 | High while the shift engine is in a word; freezes the ratio |
| sck_lvl_o | output | 1 | Registered serial clock level |
| half_tick_o | output | 1 | One-cycle strobe on each level toggle |
| edge_rise_o | output | 1 | With half_tick_o: 1 for a rising toggle, 0 for falling |

## Verification
Both encodings are instantiated side by side. Each is driven with random fields and with directed corners, and the high and low phase lengths are measured at the ports. The directed corners are the clamped values, odd ratios, the largest ratio, and fields that differ only in the ignored bits. The random fields show that the ratio formula and the bit packing match across many values. The ignored-bit pairs show that the unused bits cannot change the period. The odd ratios separate the high-phase and low-phase lengths. Mid-period field changes, with and without word_busy_i, show that the ratio is taken only at a rising toggle with no word active.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int FIELD_W = 8;
  localparam int SPR_W   = 4;
  localparam int EXP_W   = 3;
  localparam int DIV_W   = SPR_W + (1 << EXP_W) - 1;
  localparam int HALF_W  = DIV_W - 1;

  typedef enum logic {
    FMT_LEGACY   = 1'b0,
    FMT_EXTENDED = 1'b1
  } presc_fmt_e;

  function automatic logic [DIV_W-1:0] min_ratio(presc_fmt_e fmt);
    return (fmt == FMT_LEGACY) ? DIV_W'(4) : DIV_W'(2);
  endfunction
endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
  import spi_presc_pkg::*;
#(
  parameter presc_fmt_e FMT = FMT_EXTENDED
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   ratio_o
);
  generate
    if (FMT == FMT_LEGACY) begin : g_legacy
      logic [SPR_W-1:0] n;
      assign n = field_i[SPR_W-1:0];
      always_comb begin
        if (n < SPR_W'(2)) ratio_o = DIV_W'(4);
        else               ratio_o = {{(DIV_W-SPR_W-1){1'b0}}, n, 1'b0};
      end
    end else begin : g_extended
      logic [SPR_W-1:0] mant;
      logic [SPR_W-1:0] mant_eff;
      logic [EXP_W-1:0] expo;
      assign mant     = field_i[SPR_W-1:0];
      assign expo     = {field_i[7:6], field_i[4]};
      assign mant_eff = (mant < SPR_W'(2)) ? SPR_W'(2) : mant;
      assign ratio_o  = {{(DIV_W-SPR_W){1'b0}}, mant_eff} << expo;
    end
  endgenerate
endmodule

// File: rtl/spi_presc_phase.sv
module spi_presc_phase
  import spi_presc_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_RATIO = DIV_W'(2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             hold_i,
  output logic             lvl_o,
  output logic             tick_o,
  output logic             rise_o
);
  logic [DIV_W-1:0]  cur_ratio;
  logic [HALF_W-1:0] cnt;
  logic [DIV_W-1:0]  nxt_ratio;
  logic [DIV_W-1:0]  hi_len;
  logic [DIV_W-1:0]  lo_len;

  // ratio chosen at a rising boundary
  assign nxt_ratio = hold_i ? cur_ratio : ratio_i;
  // high phase rounds up, low phase rounds down
  assign hi_len    = (nxt_ratio + DIV_W'(1)) >> 1;
  assign lo_len    = cur_ratio >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o     <= 1'b0;
      tick_o    <= 1'b0;
      rise_o    <= 1'b0;
      cnt       <= '0;
      cur_ratio <= RST_RATIO;
    end else begin
      tick_o <= 1'b0;
      rise_o <= 1'b0;
      if (cnt == '0) begin
        tick_o <= 1'b1;
        lvl_o  <= ~lvl_o;
        if (!lvl_o) begin
          rise_o    <= 1'b1;
          cur_ratio <= nxt_ratio;
          cnt       <= hi_len[HALF_W-1:0] - HALF_W'(1);
        end else begin
          cnt <= lo_len[HALF_W-1:0] - HALF_W'(1);
        end
      end else begin
        cnt <= cnt - HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_clk_presc.sv
module spi_clk_presc
  import spi_presc_pkg::*;
#(
  parameter presc_fmt_e FMT = FMT_EXTENDED
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] presc_field_i,
  input  logic               word_busy_i,
  output logic               sck_lvl_o,
  output logic               half_tick_o,
  output logic               edge_rise_o
);
  logic [DIV_W-1:0] ratio;

  spi_presc_decode #(.FMT(FMT)) u_dec (
    .field_i (presc_field_i),
    .ratio_o (ratio)
  );

  spi_presc_phase #(.RST_RATIO(min_ratio(FMT))) u_phase (
    .clk     (clk),
    .rst     (rst),
    .ratio_i (ratio),
    .hold_i  (word_busy_i),
    .lvl_o   (sck_lvl_o),
    .tick_o  (half_tick_o),
    .rise_o  (edge_rise_o)
  );
endmodule

// File: rtl/spi_clk_presc_chk.sv
module spi_clk_presc_chk
  import spi_presc_pkg::*;
#(
  parameter presc_fmt_e FMT = FMT_EXTENDED
) (
  input logic clk,
  input logic rst,
  input logic sck_lvl_o,
  input logic half_tick_o,
  input logic edge_rise_o
);
  localparam int MAX_HALF = (FMT == FMT_LEGACY) ? 15 : 960;

  logic [HALF_W:0] gap;
  always_ff @(posedge clk) begin
    if (rst || half_tick_o) gap <= '0;
    else                    gap <= gap + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sck_lvl_o && !half_tick_o)); // R9
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst) half_tick_o |-> (sck_lvl_o != $past(sck_lvl_o))); // R10
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst) !half_tick_o |-> $stable(sck_lvl_o)); // R10
  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (rst) edge_rise_o |-> (half_tick_o && sck_lvl_o)); // R10
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst) gap < (HALF_W+1)'(MAX_HALF)); // R5

  generate
    if (FMT == FMT_LEGACY) begin : g_leg
      AST_LEG_MIN_HALF: assert property (@(posedge clk) disable iff (rst) half_tick_o |=> !half_tick_o); // R2
    end
  endgenerate
endmodule

bind spi_clk_presc spi_clk_presc_chk #(.FMT(FMT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sck_lvl_o   (sck_lvl_o),
  .half_tick_o (half_tick_o),
  .edge_rise_o (edge_rise_o)
);

// File: tb/sim_spi_clk_presc.sv
module sim_spi_clk_presc;
  import spi_presc_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fld [2];
  logic       busy [2];
  logic       lvl [2];
  logic       tick [2];
  logic       rise [2];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  // index 0: extended encoding, index 1: legacy encoding
  spi_clk_presc #(.FMT(FMT_EXTENDED)) u0 (
    .clk(clk), .rst(rst), .presc_field_i(fld[0]), .word_busy_i(busy[0]),
    .sck_lvl_o(lvl[0]), .half_tick_o(tick[0]), .edge_rise_o(rise[0]));
  spi_clk_presc #(.FMT(FMT_LEGACY)) u1 (
    .clk(clk), .rst(rst), .presc_field_i(fld[1]), .word_busy_i(busy[1]),
    .sck_lvl_o(lvl[1]), .half_tick_o(tick[1]), .edge_rise_o(rise[1]));

  function automatic int ref_ratio(int w, logic [7:0] f);
    int m, e;
    m = int'(f[3:0]);
    if (w == 1) return (m < 2) ? 4 : 2 * m;
    e = int'({f[7:6], f[4]});
    if (m < 2) m = 2;
    return m << e;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(int w);
    do @(negedge clk); while (!(tick[w] && rise[w]));
  endtask

  // starts at a negedge where a rising strobe is visible, ends at the next one
  task automatic measure(int w, output int hi, output int lo);
    hi = 0;
    do begin @(negedge clk); hi++; end while (!(tick[w] && !rise[w]));
    lo = 0;
    do begin @(negedge clk); lo++; end while (!(tick[w] && rise[w]));
  endtask

  task automatic try_field(int w, logic [7:0] f, string req);
    int hi, lo, d;
    fld[w] = f;
    wait_rise(w);
    measure(w, hi, lo);
    d = ref_ratio(w, f);
    check({req, " high"}, hi, (d + 1) / 2);
    check({req, " low"}, lo, d / 2);
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    void'($urandom(32'h5EED_0042));
    fld[0] = 8'h05; fld[1] = 8'h13;
    busy[0] = 1'b0; busy[1] = 1'b0;
    repeat (3) @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      check("R9 level in reset", int'(lvl[w]), 0);
      check("R9 tick in reset", int'(tick[w]), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      check("R9 first tick", int'(tick[w]), 1);
      check("R9 first rise", int'(rise[w]), 1);
      check("R10 level high", int'(lvl[w]), 1);
    end

    // legacy corners
    try_field(1, 8'h10, "R2 N=0");
    try_field(1, 8'h11, "R2 N=1");
    try_field(1, 8'h12, "R1 N=2");
    try_field(1, 8'h1F, "R1 N=15");
    try_field(1, 8'hE7, "R1 upper bits ignored");
    // extended corners
    try_field(0, 8'h00, "R4 M=0");
    try_field(0, 8'h11, "R4 M=1 E=1");
    try_field(0, 8'h03, "R6 odd ratio 3");
    try_field(0, 8'h25, "R3 bit5 ignored");
    try_field(0, 8'h13, "R3 exponent bit4");
    try_field(0, 8'hCF, "R3 exponent 6");
    try_field(0, 8'hDF, "R5 ratio 1920");

    // random fields
    for (int k = 0; k < 24; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      try_field(1, r, "R1 random legacy");
      r[7] = 1'b0;
      try_field(0, r, "R3 random extended");
    end

    // mid-period change keeps current period (R7)
    fld[0] = 8'h07;
    wait_rise(0); wait_rise(0);
    @(negedge clk);
    fld[0] = 8'h09;
    hi = 1; lo = 0;
    while (!(tick[0] && !rise[0])) begin @(negedge clk); hi++; end
    do begin @(negedge clk); lo++; end while (!(tick[0] && rise[0]));
    check("R7 current high kept", hi, 4);
    check("R7 current low kept", lo, 3);
    measure(0, hi, lo);
    check("R7 new high", hi, 5);
    check("R7 new low", lo, 4);

    // busy holds the old ratio (R8)
    busy[0] = 1'b1;
    fld[0] = 8'h04;
    wait_rise(0);
    measure(0, hi, lo);
    check("R8 held high", hi, 5);
    check("R8 held low", lo, 4);
    busy[0] = 1'b0;
    wait_rise(0);
    measure(0, hi, lo);
    check("R8 released high", hi, 2);
    check("R8 released low", lo, 2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule